// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block controls a 10-bit successive-approximation converter. A start pulse sets a busy bit. The block then waits a programmable number of conversion-clock periods so the input can settle on the sampling capacitor. Next it opens the sample switch for one period. It then resolves the result one bit per period, from the most significant bit down to the least. The converter clock is not a separate clock domain. It is a one-cycle enable pulse, `tick`, on the system clock.

The block drives the trial code for the DAC. The comparator answer comes back on `cmp_hi`. When the last bit is resolved, the result register loads, busy clears and the interrupt flag sets, all on the same clock edge. A clear pulse aborts a running conversion and leaves the result register as it was. Every completion or abort is followed by a two-period discharge of the capacitor array. Reset also starts with a discharge. Sampling starts again only after the discharge. A start request made during the discharge is held and runs when the discharge ends.

Top module: `sar_sequencer`

## Requirements
- R1: After reset: `busy`, `irq_flag`, `result` and `dac_code` are zero, `discharge` is 1 and `sample_on` is 0. After two ticks `discharge` is 0 and `sample_on` is 1.
- R2: A `go_set` pulse while idle sets `busy` on the next cycle, and `sample_on` stays 1. When `go_set` and `go_clr` arrive in the same cycle, the clear wins.
- R3: `acq_sel` picks the acquisition length N in ticks: 0→0, 1→2, 2→4, 3→6, 4→8, 5→12, 6→16, 7→20. `sample_on` stays 1 through tick N after the start and drops on tick N+1.
- R4: During bit resolution, `dac_code` is the bits decided so far with the current trial bit set. The first trial, after tick N+2, is 10'h200. A bit is kept when `cmp_hi` is 1 (input at or above the DAC level) and cleared otherwise.
- R5: On tick N+12 after the start, several things happen on one edge: `result` takes the resolved code, `busy` clears, `irq_flag` sets and `discharge` rises.
- R6: A `go_clr` pulse while a conversion runs has these effects on the next cycle: `busy` is 0 and `discharge` is 1. `result` and `irq_flag` keep their values.
- R7: Discharge lasts exactly two ticks. `sample_on` is 0 throughout and returns to 1 when discharge ends.
- R8: A `go_set` pulse during discharge sets `busy` at once. The full acquisition count then begins when discharge ends, and the conversion runs as in R3 to R5.
- R9: A `wr_res` pulse loads `wr_data` into `result` on the next edge. If a conversion loads `result` on the same edge, the conversion value wins.
- R10: `irq_flag` stays set until a `flag_clr` pulse. If it is set and cleared in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle conversion-clock enable |
| go_set | input | 1 | Start request pulse |
| go_clr | input | 1 | Clear busy / abort pulse |
| acq_sel | input | 3 | Acquisition length select |
| cmp_hi | input | 1 | Comparator: input at or above DAC level |
| wr_res | input | 1 | Software write strobe for result |
| wr_data | input | 10 | Software write data |
| flag_clr | input | 1 | Interrupt flag clear pulse |
| sample_on | output | 1 | Sample switch closed |
| discharge | output | 1 | Capacitor array discharge active |
| dac_code | output | 10 | Trial code for the DAC |
| result | output | 10 | Result register |
| irq_flag | output | 1 | Conversion-complete flag |
| busy | output | 1 | Start/busy bit |

## Verification
The bench builds the block with its default parameters: a 10-bit result and a 5-bit acquisition counter. With these defaults, all eight acquisition selects are reachable, including the 20-tick maximum, and the full MSB-to-LSB walk runs against a modelled comparator. Random tick gaps and random input levels drive the design. The bench adds the extremes 0 and 1023 and the mid-scale neighbours 511 and 512. Both clash cases are forced onto the completion edge: a software write landing together with the result load, and a flag clear landing together with the flag set.

// File: rtl/sar_sequencer.sv
module sar_sequencer #(
  parameter int RES_W = 10,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             go_set,
  input  logic             go_clr,
  input  logic [2:0]       acq_sel,
  input  logic             cmp_hi,
  input  logic             wr_res,
  input  logic [RES_W-1:0] wr_data,
  input  logic             flag_clr,
  output logic             sample_on,
  output logic             discharge,
  output logic [RES_W-1:0] dac_code,
  output logic [RES_W-1:0] result,
  output logic             irq_flag,
  output logic             busy
);
  localparam int IDX_W = $clog2(RES_W);

  typedef enum logic [2:0] {S_DISCH, S_IDLE, S_ACQ, S_HOLD, S_CONV} state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] bidx;
  logic [RES_W-1:0] decided;
  logic             dcnt;
  logic             running, abort, load_now, busy_d;
  logic [RES_W-1:0] trial, final_code;

  function automatic logic [CNT_W-1:0] acq_tads(input logic [2:0] sel);
    case (sel)
      3'd0: acq_tads = CNT_W'(0);
      3'd1: acq_tads = CNT_W'(2);
      3'd2: acq_tads = CNT_W'(4);
      3'd3: acq_tads = CNT_W'(6);
      3'd4: acq_tads = CNT_W'(8);
      3'd5: acq_tads = CNT_W'(12);
      3'd6: acq_tads = CNT_W'(16);
      default: acq_tads = CNT_W'(20);
    endcase
  endfunction

  assign running    = (state == S_ACQ) || (state == S_HOLD) || (state == S_CONV);
  assign abort      = go_clr && running;
  assign load_now   = (state == S_CONV) && tick && !go_clr && (bidx == '0);
  assign trial      = RES_W'(1) << bidx;
  assign final_code = decided | RES_W'(cmp_hi);

  always_comb begin
    if (go_clr || load_now) busy_d = 1'b0;
    else if (go_set)        busy_d = 1'b1;
    else                    busy_d = busy;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_DISCH;
      dcnt     <= 1'b0;
      cnt      <= '0;
      bidx     <= '0;
      decided  <= '0;
      result   <= '0;
      irq_flag <= 1'b0;
      busy     <= 1'b0;
    end else begin
      busy <= busy_d;

      if (load_now)    result <= final_code;
      else if (wr_res) result <= wr_data;

      if (load_now)      irq_flag <= 1'b1;
      else if (flag_clr) irq_flag <= 1'b0;

      if (abort) begin
        state <= S_DISCH;
        dcnt  <= 1'b0;
      end else begin
        case (state)
          S_DISCH: if (tick) begin
            if (dcnt) begin
              dcnt <= 1'b0;
              if (busy_d) begin
                state <= S_ACQ;
                cnt   <= acq_tads(acq_sel);
              end else begin
                state <= S_IDLE;
              end
            end else begin
              dcnt <= 1'b1;
            end
          end
          S_IDLE: if (go_set && !go_clr) begin
            state <= S_ACQ;
            cnt   <= acq_tads(acq_sel);
          end
          S_ACQ: if (tick) begin
            if (cnt == '0) state <= S_HOLD;
            else           cnt   <= cnt - CNT_W'(1);
          end
          S_HOLD: if (tick) begin
            state   <= S_CONV;
            bidx    <= IDX_W'(RES_W - 1);
            decided <= '0;
          end
          S_CONV: if (tick) begin
            decided[bidx] <= cmp_hi;
            if (bidx == '0) begin
              state <= S_DISCH;
              dcnt  <= 1'b0;
            end else begin
              bidx <= bidx - IDX_W'(1);
            end
          end
          default: state <= S_DISCH;
        endcase
      end
    end
  end

  assign sample_on = (state == S_IDLE) || (state == S_ACQ);
  assign discharge = (state == S_DISCH);
  assign dac_code  = (state == S_CONV) ? (decided | trial) : '0;
endmodule

// File: rtl/sar_sequencer_chk.sv
module sar_sequencer_chk #(
  parameter int RES_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             go_clr,
  input logic             wr_res,
  input logic             sample_on,
  input logic             discharge,
  input logic [RES_W-1:0] dac_code,
  input logic [RES_W-1:0] result,
  input logic             irq_flag,
  input logic             busy
);
  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_res && !busy) |=> $stable(result));

  p_flag_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> $fell(busy));

  p_busy_end_discharge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> discharge);

  p_dac_steps_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !go_clr) |=> $stable(dac_code));

  p_hold_only_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sample_on) && !discharge) |-> busy);

  p_disch_ends_sampling_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(discharge) |-> sample_on);
endmodule

bind sar_sequencer sar_sequencer_chk #(.RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .go_clr(go_clr), .wr_res(wr_res),
  .sample_on(sample_on), .discharge(discharge), .dac_code(dac_code),
  .result(result), .irq_flag(irq_flag), .busy(busy)
);

// File: tb/sar_sequencer_tb.sv
module sar_sequencer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, go_set = 1'b0, go_clr = 1'b0, wr_res = 1'b0, flag_clr = 1'b0;
  logic [2:0] acq_sel = 3'd0;
  logic [9:0] wr_data = '0;
  logic       cmp_hi;
  logic       sample_on, discharge, irq_flag, busy;
  logic [9:0] dac_code, result;
  int         model_vin = 0;
  int         checks = 0, fails = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  assign cmp_hi = (model_vin >= int'(dac_code));

  sar_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .go_set(go_set), .go_clr(go_clr),
    .acq_sel(acq_sel), .cmp_hi(cmp_hi), .wr_res(wr_res), .wr_data(wr_data),
    .flag_clr(flag_clr), .sample_on(sample_on), .discharge(discharge),
    .dac_code(dac_code), .result(result), .irq_flag(irq_flag), .busy(busy)
  );

  function automatic int exp_tads(input int sel);
    case (sel)
      0: return 0;  1: return 2;  2: return 4;  3: return 6;
      4: return 8;  5: return 12; 6: return 16; default: return 20;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic pulse_tick();
    repeat ($urandom_range(0, 2)) @(negedge clk);
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic pulse_go();
    @(negedge clk) go_set = 1'b1;
    @(negedge clk) go_set = 1'b0;
  endtask

  task automatic disch_end(input bit exp_busy);
    pulse_tick();
    chk("R7 discharge mid", discharge, 1);
    chk("R7 sample off", sample_on, 0);
    pulse_tick();
    chk("R7 discharge end", discharge, 0);
    chk("R7 sample back", sample_on, 1);
    chk("R8 busy after discharge", busy, exp_busy);
  endtask

  task automatic run_conv(input int v, input int sel, input bit started,
                          input bit wr_clash, input bit clr_clash);
    int n = exp_tads(sel);
    model_vin = v;
    acq_sel = 3'(sel);
    if (!started) begin
      pulse_go();
      chk("R2 busy set", busy, 1);
      chk("R2 sampling", sample_on, 1);
    end
    for (int k = 1; k <= n + 12; k++) begin
      repeat ($urandom_range(0, 2)) @(negedge clk);
      @(negedge clk);
      tick = 1'b1;
      if (k == n + 12) begin
        wr_res = wr_clash; wr_data = 10'(~v); flag_clr = clr_clash;
      end
      @(negedge clk);
      tick = 1'b0; wr_res = 1'b0; flag_clr = 1'b0;
      if (n > 0 && k == n) chk("R3 still sampling", sample_on, 1);
      if (k == n + 1) chk("R3 hold opens", sample_on, 0);
      if (k == n + 2) chk("R4 first trial", dac_code, 10'h200);
      if (k == n + 3) chk("R4 second trial", dac_code, (v & 10'h200) | 10'h100);
      if (k == n + 11) chk("R5 busy before end", busy, 1);
    end
    chk("R5 busy cleared", busy, 0);
    chk(wr_clash ? "R9 load beats write" : "R5 result", result, v);
    chk(clr_clash ? "R10 set beats clear" : "R5 irq set", irq_flag, 1);
    chk("R5 discharge starts", discharge, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int keep;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 irq", irq_flag, 0);
    chk("R1 result", result, 0);
    chk("R1 dac", dac_code, 0);
    chk("R1 discharge", discharge, 1);
    chk("R1 sample", sample_on, 0);
    disch_end(0);

    @(negedge clk) begin go_set = 1'b1; go_clr = 1'b1; end
    @(negedge clk) begin go_set = 1'b0; go_clr = 1'b0; end
    chk("R2 clear wins", busy, 0);
    chk("R2 still idle", sample_on, 1);

    run_conv(0, 0, 0, 0, 0);
    disch_end(0);
    run_conv(1023, 7, 0, 0, 0);
    disch_end(0);
    run_conv(512, 2, 0, 1, 1);
    disch_end(0);

    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
    chk("R10 flag cleared", irq_flag, 0);

    run_conv(511, 1, 0, 0, 0);
    acq_sel = 3'd3;
    pulse_go();
    chk("R8 held start", busy, 1);
    disch_end(1);
    run_conv(300, 3, 1, 0, 0);
    disch_end(0);

    @(negedge clk) begin wr_res = 1'b1; wr_data = 10'd77; end
    @(negedge clk) wr_res = 1'b0;
    chk("R9 write", result, 77);
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;

    for (int a = 0; a < 3; a++) begin
      int sel = $urandom_range(0, 7);
      int stop = $urandom_range(1, exp_tads(sel) + 11);
      model_vin = $urandom_range(0, 1023);
      acq_sel = 3'(sel);
      keep = result;
      pulse_go();
      repeat (stop) pulse_tick();
      @(negedge clk) go_clr = 1'b1;
      @(negedge clk) go_clr = 1'b0;
      chk("R6 busy", busy, 0);
      chk("R6 discharge", discharge, 1);
      chk("R6 result kept", result, keep);
      chk("R6 irq kept", irq_flag, 0);
      disch_end(0);
    end

    for (int i = 0; i < 20; i++) begin
      run_conv($urandom_range(0, 1023), $urandom_range(0, 7), 0, 0, 0);
      disch_end(0);
    end
    summary();
  end
endmodule